// File: doc/BRIEF.md
# Slot-Rotated Interrupt Pin Router

This block takes the level-sensitive interrupt pins of up to 32 expansion-bus slots, four pins per slot (A to D), and sends them to a 16-input legacy interrupt controller. First it folds the pins onto four shared request lines. The fold depends on the slot number, so the first pins of neighbouring slots land on different lines. Next, each shared line goes through a byte-wide steering register to one controller input, or to none. The controller side receives a 16-bit level vector. Each bit of that vector is the OR of every shared line that is enabled and steered to it.

Software programs the four steering registers through a byte-wide write and read port. Each register sits at its own fixed offset. The data path from device pins to controller levels has no registers, so a level follows its pins with no clock delay. A new steering value takes effect on the clock edge that writes it. Triggering mode (edge or level) belongs to the controller and is not handled here.

Top module: `pirq_router`

## Requirements
- R1: Pin p (0 = A to 3 = D) of slot s feeds shared line (p + s + 3) mod 4. Examples: slot 1 pin A goes to line 0, and slot 0 pin A goes to line 3.
- R2: A shared line is high whenever any device pin that folds onto it is high, from any number of slots.
- R3: The steering registers for shared lines 0, 1, 2 and 3 sit at offsets 0x60, 0x61, 0x62 and 0x63. A write sets all 8 bits, and a read returns the full 8-bit value that was written.
- R4: After reset, all four steering registers read 0x80. With every device pin high, all 16 outputs stay low.
- R5: A steering value of 16 or more disables its shared line, so that line drives no output.
- R6: Output bit n is the OR of every enabled shared line whose steering register holds n. Two lines steered to the same n keep bit n high while either one is high.
- R7: Outputs follow the device pins combinationally, with no clock edge needed. When a steering register is rewritten, the level moves to the new output right after that write edge and leaves the old output clear.
- R8: A write to an offset outside 0x60 to 0x63 changes no steering register. A read of such an offset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the steering registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_irq | input | 128 | Device pin levels; bit slot*4+pin |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pic_irq | output | 16 | Level vector to the interrupt controller |

## Verification
The bench builds the router with its default parameters: 32 slots, 16 controller inputs and a register base of 0x60. Slot 0 and slot 31 are both reachable, so the wrap of the fold at both ends of the slot range is exercised. All sixteen outputs, the disable threshold at 16, and values just below it (15) can also be steered to. The default base places out-of-range offsets 0x5F and 0x64 right beside the register window.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int LINES = 4;
  localparam int RW    = 8;

  typedef logic [RW-1:0] route_t;

  // shared line reached by a given pin of a given slot
  function automatic logic [1:0] line_of(int unsigned slot, int unsigned pin);
    int unsigned t;
    t = pin + slot + LINES - 1;
    return 2'(t % LINES);
  endfunction

  // true when steering value r enables its line onto output idx
  function automatic logic steers_to(route_t r, int unsigned idx, int unsigned n_outs);
    return (32'(r) < n_outs) && (32'(r) == idx);
  endfunction

  // index of a steering register addressed by addr, or LINES when none
  function automatic int unsigned reg_index(logic [7:0] addr, logic [7:0] base);
    if (addr >= base && 32'(addr) < 32'(base) + LINES)
      return 32'(addr - base);
    return LINES;
  endfunction
endpackage

// File: rtl/pirq_fold.sv
module pirq_fold import pirq_pkg::*; #(
  parameter int NUM_SLOTS = 32,
  localparam int PIN_W = NUM_SLOTS * LINES
) (
  input  logic [PIN_W-1:0] dev_irq,
  output logic [LINES-1:0] line_lvl
);
  always_comb begin
    line_lvl = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int p = 0; p < LINES; p++) begin
        if (dev_irq[s*LINES + p])
          line_lvl[line_of(s, p)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pirq_steer_regs.sv
module pirq_steer_regs import pirq_pkg::*; #(
  parameter logic [7:0] REG_BASE = 8'h60,
  parameter route_t     RST_VAL  = 8'h80
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [7:0]          reg_addr,
  input  logic [RW-1:0]       reg_wdata,
  output logic [RW-1:0]       reg_rdata,
  output logic [LINES*RW-1:0] route_flat
);
  int unsigned sel;
  assign sel = reg_index(reg_addr, REG_BASE);

  for (genvar k = 0; k < LINES; k++) begin : g_reg
    route_t r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        r_q <= RST_VAL;
      else if (reg_wr && sel == k)
        r_q <= reg_wdata;
    end
    assign route_flat[k*RW +: RW] = r_q;
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < LINES; k++)
      if (sel == k) reg_rdata = route_flat[k*RW +: RW];
  end
endmodule

// File: rtl/pirq_fanout.sv
module pirq_fanout import pirq_pkg::*; #(
  parameter int NUM_OUTS = 16
) (
  input  logic [LINES-1:0]    line_lvl,
  input  logic [LINES*RW-1:0] route_flat,
  output logic [NUM_OUTS-1:0] pic_irq
);
  always_comb begin
    pic_irq = '0;
    for (int j = 0; j < NUM_OUTS; j++)
      for (int k = 0; k < LINES; k++)
        if (line_lvl[k] && steers_to(route_flat[k*RW +: RW], j, NUM_OUTS))
          pic_irq[j] = 1'b1;
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router import pirq_pkg::*; #(
  parameter int         NUM_SLOTS = 32,
  parameter int         NUM_OUTS  = 16,
  parameter logic [7:0] REG_BASE  = 8'h60,
  localparam int        PIN_W     = NUM_SLOTS * LINES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PIN_W-1:0]    dev_irq,
  input  logic                reg_wr,
  input  logic [7:0]          reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  output logic [NUM_OUTS-1:0] pic_irq
);
  logic [LINES-1:0]    line_lvl;
  logic [LINES*RW-1:0] route_flat;

  pirq_fold #(.NUM_SLOTS(NUM_SLOTS)) u_fold (
    .dev_irq (dev_irq),
    .line_lvl(line_lvl)
  );

  pirq_steer_regs #(.REG_BASE(REG_BASE), .RST_VAL(8'h80)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .route_flat(route_flat)
  );

  pirq_fanout #(.NUM_OUTS(NUM_OUTS)) u_fan (
    .line_lvl  (line_lvl),
    .route_flat(route_flat),
    .pic_irq   (pic_irq)
  );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk import pirq_pkg::*; #(
  parameter int         NUM_SLOTS = 32,
  parameter int         NUM_OUTS  = 16,
  parameter logic [7:0] REG_BASE  = 8'h60
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_SLOTS*LINES-1:0] dev_irq,
  input logic                      reg_wr,
  input logic [7:0]                reg_addr,
  input logic [7:0]                reg_wdata,
  input logic [NUM_OUTS-1:0]       pic_irq,
  input logic [LINES-1:0]          line_lvl,
  input logic [LINES*RW-1:0]       route_flat
);
  logic out_of_window;
  assign out_of_window = (reg_addr < REG_BASE) || (32'(reg_addr) >= 32'(REG_BASE) + LINES);

  AST_QUIET_PINS_QUIET_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_irq == '0) |-> (line_lvl == '0)); // R2

  AST_QUIET_LINES_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (line_lvl == '0) |-> (pic_irq == '0)); // R6

  AST_FOREIGN_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && out_of_window) |=> $stable(route_flat)); // R8

  for (genvar k = 0; k < LINES; k++) begin : g_line
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 8'(32'(REG_BASE) + k)) |=> (route_flat[k*RW +: RW] == $past(reg_wdata))); // R3

    AST_LIVE_LINE_REACHES: assert property (@(posedge clk) disable iff (!rst_n)
      (line_lvl[k] && route_flat[k*RW +: RW] < 8'(NUM_OUTS))
        |-> pic_irq[route_flat[k*RW +: 4]]); // R6

    AST_HIGH_VALUE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      (route_flat[k*RW +: RW] >= 8'(NUM_OUTS) && line_lvl == (LINES'(1) << k))
        |-> (pic_irq == '0)); // R5
  end
endmodule

bind pirq_router pirq_router_chk #(
  .NUM_SLOTS(NUM_SLOTS), .NUM_OUTS(NUM_OUTS), .REG_BASE(REG_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pic_irq(pic_irq),
  .line_lvl(line_lvl), .route_flat(route_flat)
);

// File: tb/test_pirq_router.sv
module test_pirq_router;
  localparam int SLOTS = 32;
  localparam int OUTS  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [SLOTS*4-1:0] dev_irq = '0;
  logic              reg_wr = 1'b0;
  logic [7:0]        reg_addr = '0;
  logic [7:0]        reg_wdata = '0;
  logic [7:0]        reg_rdata;
  logic [OUTS-1:0]   pic_irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  pirq_router #(.NUM_SLOTS(SLOTS), .NUM_OUTS(OUTS), .REG_BASE(8'h60)) i_pirq_router (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pic_irq(pic_irq)
  );

  // {routes r3..r0 [63:32], slot [31:24], pin [23:16], expected out [15:0]}
  localparam logic [63:0] VEC [12] = '{
    {32'h09070503, 8'd1,  8'd0, 16'h0008},  // R1 slot1 A -> line0 -> 3
    {32'h09070503, 8'd1,  8'd3, 16'h0200},  // R1 slot1 D -> line3 -> 9
    {32'h09070503, 8'd0,  8'd0, 16'h0200},  // R1 slot0 A wraps to line3
    {32'h09070503, 8'd0,  8'd1, 16'h0008},  // R1 slot0 B -> line0
    {32'h09070503, 8'd2,  8'd0, 16'h0020},  // R1 slot2 A -> line1 -> 5
    {32'h09070503, 8'd31, 8'd0, 16'h0080},  // R1 slot31 A -> line2 -> 7
    {32'h09070503, 8'd31, 8'd3, 16'h0020},  // R1 slot31 D -> line1
    {32'h0A0A0A0A, 8'd7,  8'd1, 16'h0400},  // R6 all lines -> 10
    {32'h800F1000, 8'd1,  8'd0, 16'h0001},  // R6 line0 -> output 0
    {32'h800F1000, 8'd1,  8'd1, 16'h0000},  // R5 value 16 disables
    {32'h800F1000, 8'd1,  8'd2, 16'h8000},  // R6 value 15 -> top output
    {32'h800F1000, 8'd1,  8'd3, 16'h0000}   // R5 value 0x80 disables
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pin(int s, int p, logic v);
    dev_irq[s*4 + p] = v;
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    #20;
    // reset state
    dev_irq = '1;
    #1;
    check("R4 outputs low at reset", 32'(pic_irq), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      rd(8'(8'h60 + k), d);
      check("R4 reset value", 32'(d), 32'h80);
    end
    #1;
    check("R4 all pins high, lines disabled", 32'(pic_irq), 32'h0);
    dev_irq = '0;

    // table walk
    for (int i = 0; i < 12; i++) begin
      for (int k = 0; k < 4; k++) wr(8'(8'h60 + k), VEC[i][32 + k*8 +: 8]);
      dev_irq = '0;
      pin(int'(VEC[i][31:24]), int'(VEC[i][23:16]), 1'b1);
      #1;
      check($sformatf("R1/R5/R6 vector %0d", i), 32'(pic_irq), 32'(VEC[i][15:0]));
      dev_irq = '0;
    end

    // R3 full-byte readback
    wr(8'h62, 8'hA5);
    rd(8'h62, d);
    check("R3 readback 0x62", 32'(d), 32'hA5);
    wr(8'h63, 8'h3C);
    rd(8'h63, d);
    check("R3 readback 0x63", 32'(d), 32'h3C);

    // R8 foreign offsets
    wr(8'h60, 8'h02);
    wr(8'h5F, 8'h00);
    wr(8'h64, 8'h00);
    rd(8'h60, d);
    check("R8 0x60 untouched", 32'(d), 32'h02);
    rd(8'h63, d);
    check("R8 0x63 untouched", 32'(d), 32'h3C);
    rd(8'h64, d);
    check("R8 read outside window", 32'(d), 32'h0);
    pin(1, 0, 1'b1);
    #1;
    check("R8 routing intact", 32'(pic_irq), 32'h0004);
    dev_irq = '0;

    // R6 shared target, R2 multi-slot OR
    wr(8'h60, 8'd6); wr(8'h61, 8'd6);
    pin(1, 0, 1'b1); pin(1, 1, 1'b1);
    #1;
    check("R6 two lines one output", 32'(pic_irq), 32'h0040);
    pin(1, 0, 1'b0);
    #1;
    check("R6 one line still holds", 32'(pic_irq), 32'h0040);
    pin(1, 1, 1'b0);
    #1;
    check("R6 both low", 32'(pic_irq), 32'h0);
    pin(1, 0, 1'b1); pin(5, 0, 1'b1);
    #1;
    check("R2 two slots on line0", 32'(pic_irq), 32'h0040);
    pin(1, 0, 1'b0);
    #1;
    check("R2 other slot keeps line0", 32'(pic_irq), 32'h0040);
    dev_irq = '0;

    // R7 combinational follow and retarget
    wr(8'h60, 8'd3);
    pin(9, 0, 1'b1); // (0+9+3)%4 = 0
    #1;
    check("R7 follows pin without clock", 32'(pic_irq), 32'h0008);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h60; reg_wdata = 8'd4;
    #1;
    check("R7 old target before edge", 32'(pic_irq), 32'h0008);
    @(posedge clk); #1;
    check("R7 moved after write edge", 32'(pic_irq), 32'h0010);
    @(negedge clk); reg_wr = 1'b0;
    pin(9, 0, 1'b0);
    #1;
    check("R7 release clears", 32'(pic_irq), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule